// File: doc/BRIEF.md
# SPI Register Port for a Sixteen-Entry Register File

This block sits between a serial peripheral bus and a small parallel register file of sixteen 8-bit entries. The bus master selects the block by raising chip select. It then sends a command byte followed by any number of data bytes. The block turns these into single-cycle write or read strobes on a parallel port, and the register file is attached to that port. The contents and side effects of the registers are outside this block.

The command byte carries three fields. A marker bit must be set for the command to be accepted. A direction bit selects read or write. The low nibble is the starting register address. The address advances by one after every data byte, so a whole group of registers can be moved after a single command. An example is a seven-byte time group or a four-byte alarm group. The serial pins are brought into the system clock domain through synchronizers. All parallel-side activity is therefore synchronous to `clk`.

Top module: `spi_reg_port`

## Requirements
- R1: The first byte after chip select rises is a command, received MSB first. Bit 4 must be 1 for the command to be accepted. Bit 7 = 1 selects read and bit 7 = 0 selects write. Bits 3:0 give the start address, so a write command is 0x10|addr and a read command is 0x90|addr.
- R2: During a write, every complete data byte produces exactly one single-cycle `reg_we` pulse. During that pulse, `reg_addr` holds the current address and `reg_wdata` holds the byte.
- R3: After each data byte, the address advances by one and wraps from 0xF to 0x0.
- R4: During a read, a `reg_re` pulse is issued for the start address once the command is complete. `reg_rdata` is taken in that same cycle. The byte is driven on `spi_miso` MSB first, with the first bit present before the first rising SCK of the data byte. Each later bit changes only after a falling SCK edge (SPI mode 0).
- R5: After each read data byte completes, a `reg_re` pulse is issued for the next address, ahead of the next byte. A burst of n bytes therefore produces n+1 reads.
- R6: If a command has bit 4 = 0, the rest of the selection is ignored. No strobes are issued and `spi_miso` stays 0 until chip select falls.
- R7: Bits of an incomplete data byte at deselect are discarded, and no strobe is issued for them.
- R8: Chip select is active high. Every rising edge starts a fresh command. While the block is deselected, `spi_miso` is 0 and no strobe is issued.
- R9: After reset, `reg_we`, `reg_re` and `spi_miso` are 0.
- R10: `reg_we` and `reg_re` are never high in the same cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| reg_addr | output | ADDR_W | Register address for the strobe |
| reg_wdata | output | DATA_W | Write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | DATA_W | Read data, valid in the cycle `reg_re` is high |
| reg_re | output | 1 | Single-cycle read strobe |

## Verification
The checks assume that each SCK phase lasts several system clocks, longer than the synchronizer delay plus one cycle. They also assume that chip select stays low for at least a few system clocks between selections. This lets the address-step check treat every strobe in one selection as part of one burst. The stimulus holds each SCK phase for eight clocks. It changes MOSI only while SCK is low, and it keeps chip select low for sixteen clocks between transactions. The register file answers combinationally from an array inside the bench.

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_re
);
  localparam int CNT_W    = $clog2(DATA_W);
  localparam int MARK_BIT = ADDR_W;
  localparam int DIR_BIT  = DATA_W - 1;

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_WR, ST_RD, ST_SKIP} st_t;

  st_t                   state;
  logic [SYNC_STAGES-1:0] sck_sy, cs_sy, mosi_sy;
  logic                  sck_q, cs_q;
  logic [DATA_W-2:0]     rx_sh;
  logic [DATA_W-1:0]     tx_sh;
  logic [CNT_W-1:0]      bit_cnt;

  logic sck_s, cs_s, mosi_s;
  assign sck_s  = sck_sy[SYNC_STAGES-1];
  assign cs_s   = cs_sy[SYNC_STAGES-1];
  assign mosi_s = mosi_sy[SYNC_STAGES-1];

  logic sck_rise, sck_fall, cs_rise, byte_done;
  logic [DATA_W-1:0] rx_byte;
  assign sck_rise  = cs_s & sck_s & ~sck_q;
  assign sck_fall  = cs_s & ~sck_s & sck_q;
  assign cs_rise   = cs_s & ~cs_q;
  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_done = sck_rise && (bit_cnt == CNT_W'(DATA_W - 1));

  assign spi_miso = (state == ST_RD) & tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '0;
      mosi_sy <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[SYNC_STAGES-2:0], spi_sck};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], spi_cs};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], spi_mosi};
      sck_q   <= sck_s;
      cs_q    <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rx_sh     <= '0;
      tx_sh     <= '0;
      bit_cnt   <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      if (reg_we) reg_addr <= reg_addr + 1'b1;
      if (reg_re) tx_sh <= reg_rdata;

      if (!cs_s) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
      end else if (cs_rise) begin
        state   <= ST_CMD;
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= rx_byte[DATA_W-2:0];
          bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
        if (sck_fall && bit_cnt != '0 && state == ST_RD)
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        if (byte_done) begin
          case (state)
            ST_CMD: begin
              if (rx_byte[MARK_BIT]) begin
                reg_addr <= rx_byte[ADDR_W-1:0];
                if (rx_byte[DIR_BIT]) begin
                  state  <= ST_RD;
                  reg_re <= 1'b1;
                end else begin
                  state <= ST_WR;
                end
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_WR: begin
              reg_we    <= 1'b1;
              reg_wdata <= rx_byte;
            end
            ST_RD: begin
              reg_addr <= reg_addr + 1'b1;
              reg_re   <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              spi_miso,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr
);
  logic [ADDR_W-1:0] last_addr;
  logic              have_last;
  logic              cs_was;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      have_last <= 1'b0;
      cs_was    <= 1'b0;
    end else begin
      cs_was <= cs_s;
      if (!cs_s) have_last <= 1'b0;
      else if (reg_we || reg_re) begin
        have_last <= 1'b1;
        last_addr <= reg_addr;
      end
    end
  end

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  p_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_re_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  p_strobe_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |-> cs_s);
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_was) |-> !spi_miso);
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_we || reg_re) && have_last) |-> reg_addr == ADDR_W'(last_addr + 1'b1));
endmodule

bind spi_reg_port spi_reg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_s     (cs_s),
  .spi_miso (spi_miso),
  .reg_we   (reg_we),
  .reg_re   (reg_re),
  .reg_addr (reg_addr)
);

// File: tb/spi_reg_port_tb.sv
module spi_reg_port_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs = 1'b0, spi_mosi = 1'b0;
  logic spi_miso;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic reg_we, reg_re;

  always #5 clk = ~clk;

  spi_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re)
  );

  logic [7:0] mem [16];
  logic [7:0] model [16];
  logic [3:0] exp_wa[$];
  logic [7:0] exp_wd[$];
  logic [3:0] exp_ra[$];
  int nchk = 0, nerr = 0;
  bit done = 0;

  assign reg_rdata = mem[reg_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin
      if (exp_wa.size() == 0) chk("R2 unexpected write strobe", 1, 0);
      else begin
        chk("R2 write address", reg_addr, exp_wa.pop_front());
        chk("R2 write data", reg_wdata, exp_wd.pop_front());
      end
      mem[reg_addr] = reg_wdata;
    end
    if (reg_re) begin
      if (exp_ra.size() == 0) chk("R5 unexpected read strobe", 1, 0);
      else chk("R5 read address", reg_addr, exp_ra.pop_front());
    end
  end

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = spi_miso;
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic sel_on();
    @(negedge clk);
    spi_cs = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_off(input string req);
    repeat (HALF) @(negedge clk);
    spi_cs = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    chk({req, " pending writes"}, exp_wa.size(), 0);
    chk({req, " pending reads"}, exp_ra.size(), 0);
    chk("R8 miso low when deselected", spi_miso, 0);
  endtask

  task automatic wr_burst(input logic [3:0] a, input int n, input logic [7:0] seed);
    logic [7:0] rx, d;
    sel_on();
    xfer(8'h10 | {4'h0, a}, 8, rx);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 29);
      exp_wa.push_back(a + 4'(k));
      exp_wd.push_back(d);
      model[a + 4'(k)] = d;
      xfer(d, 8, rx);
    end
    sel_off("R2 R3 write burst");
  endtask

  task automatic rd_burst(input logic [3:0] a, input int n);
    logic [7:0] rx;
    for (int k = 0; k <= n; k++) exp_ra.push_back(a + 4'(k));
    sel_on();
    xfer(8'h90 | {4'h0, a}, 8, rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      chk("R4 read byte on miso", rx, model[a + 4'(k)]);
    end
    sel_off("R4 R5 read burst");
  endtask

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'hA0 ^ 8'(i * 37);
      model[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk("R9 reset reg_we", reg_we, 0);
    chk("R9 reset reg_re", reg_re, 0);
    chk("R9 reset miso", spi_miso, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3: seven-byte write from address 2
    wr_burst(4'h2, 7, 8'h31);
    // R4 R5: read the same group back
    rd_burst(4'h2, 7);
    // R3: write wrapping 0xE -> 0x1
    wr_burst(4'hE, 4, 8'hC5);
    // R3 R5: read wrapping from 0xF
    rd_burst(4'hF, 3);
    rd_burst(4'h0, 1);

    // R6: marker bit clear, looks like write
    sel_on();
    xfer(8'h05, 8, rx);
    for (int k = 0; k < 3; k++) begin
      xfer(8'hFF, 8, rx);
      chk("R6 ignored command miso", rx, 8'h00);
    end
    sel_off("R6 ignored write");
    // R6: marker bit clear with direction bit set
    sel_on();
    xfer(8'h85, 8, rx);
    xfer(8'hFF, 8, rx);
    chk("R6 ignored read-like command miso", rx, 8'h00);
    sel_off("R6 ignored read");

    // R7: one full byte then five bits before deselect
    sel_on();
    xfer(8'h13, 8, rx);
    exp_wa.push_back(4'h3);
    exp_wd.push_back(8'h5A);
    model[3] = 8'h5A;
    xfer(8'h5A, 8, rx);
    xfer(8'hE7, 5, rx);
    sel_off("R7 partial byte");
    // R8: fresh command after partial, data at 3 and 4 intact
    rd_burst(4'h3, 2);

    // R8: command only, no data
    sel_on();
    xfer(8'h17, 8, rx);
    sel_off("R8 command only");
    rd_burst(4'h7, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog R8 actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule